// File: doc/BRIEF.md
# Clocked Synchronous Serial Transmitter with Byte FIFO

This block sends bytes over a clocked synchronous serial link. A host pushes bytes through a simple write port into a 64-entry transmit FIFO. While the transmitter is enabled and the FIFO holds data, a shift register takes one byte at a time. It sends the byte least significant bit first on the data pin. Consecutive bytes follow one another with no gap between them.

The serial clock has two sources. The first is a divided copy of the system clock, which the block drives out on its clock pin; each data bit changes on a falling edge of that pin. The second is an external serial clock. It is synchronised into the system domain, and its edges pace the shifter. A FIFO-low flag compares the fill level against a programmable trigger level and can raise an interrupt. A transmit-done flag reports that the FIFO ran dry at the end of a byte. A sticky overflow bit records writes that were refused.

Top module: `sync_ser_tx`

## Requirements
- R1: The FIFO stores up to DEPTH (64) bytes, and `fifo_count` reports how many it holds. It reads 0 after reset. Each accepted write raises it by one, and each byte taken by the shifter lowers it by one.
- R2: A write while `fifo_count` equals DEPTH is dropped: the count and the transmitted data do not change. The write also sets `overflow`, which stays at 1 until reset.
- R3: In the cycle after `fifo_count` is at or below `trig_level`, `empty_flag` is 1. After reset `empty_flag` is 1.
- R4: `empty_flag` returns to 0 only after a `flag_clr` pulse in a cycle where `fifo_count` is above `trig_level`. It never clears by itself.
- R5: `irq` is 1 exactly when both `empty_flag` and `irq_en` are 1.
- R6: Each byte goes out least significant bit first, bit 0 through bit 7.
- R7: With the internal clock selected (`ext_clk_sel`=0), each byte produces exactly eight rising edges on `sclk_out`. `txd` changes only in the cycle where `sclk_out` falls.
- R8: While bytes remain in the FIFO, frames run back to back. Consecutive rising edges of `sclk_out` are always 2*DIV_HALF system cycles apart, including across byte boundaries.
- R9: If the FIFO is empty when a byte's last bit completes, `tx_end` becomes 1. From then on `txd` holds the value of that last bit. `tx_end` is 1 after reset.
- R10: An accepted write clears `tx_end` on the next cycle.
- R11: `sclk_out` is high whenever no byte is being shifted. It is always high while `ext_clk_sel`=1.
- R12: While `enable`=0, no new byte leaves the FIFO and `sclk_out` stays high. Data waiting in the FIFO goes out once `enable` returns to 1.
- R13: With `ext_clk_sel`=1, every falling edge of `ext_sclk_in` presents the next bit on `txd`, and the following rising edge completes that bit. Eight such pulses send one byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Transmitter enable |
| irq_en | input | 1 | Interrupt enable for the FIFO-low flag |
| ext_clk_sel | input | 1 | 1 selects the external serial clock |
| trig_level | input | 7 | FIFO-low trigger level |
| flag_clr | input | 1 | Clear strobe for `empty_flag` |
| wr_valid | input | 1 | Write strobe for one byte |
| wr_data | input | 8 | Byte to enqueue |
| ext_sclk_in | input | 1 | External serial clock |
| sclk_out | output | 1 | Serial clock driven out (internal mode) |
| txd | output | 1 | Serial data |
| empty_flag | output | 1 | FIFO at or below trigger level |
| irq | output | 1 | Transmit interrupt request |
| tx_end | output | 1 | Transmission finished with the FIFO empty |
| overflow | output | 1 | Sticky refused-write indicator |
| fifo_count | output | 7 | Bytes held in the FIFO |

## Verification
The hardest situation to reach is a full FIFO that is still being drained in a long, unbroken stream. It is reached by holding `enable` low, writing 65 bytes so the last one is refused, and then enabling the transmitter. The bench then confirms that exactly 64 bytes arrive in order, with a constant clock period across all byte boundaries. External-clock mode is reached by toggling `ext_sclk_in` slowly enough that the synchroniser delay falls inside each half period. The bench samples `txd` just before each rising edge.

// File: rtl/sync_tx_pkg.sv
package sync_tx_pkg;

    typedef logic [7:0] tx_byte_t;

    typedef enum logic {
        SH_IDLE  = 1'b0,
        SH_SHIFT = 1'b1
    } shift_state_e;

    typedef struct packed {
        logic fall;
        logic rise;
    } sclk_ev_t;

    localparam int unsigned BITS_PER_FRAME = 8;

    function automatic logic wire_bit(tx_byte_t b, logic [2:0] pos);
        return b[pos];
    endfunction

endpackage

// File: rtl/sync_tx_fifo.sv
module sync_tx_fifo #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned DW    = 8,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] pop_data,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty,
    output logic          push_rej
);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    assign full     = (count == FULL_CNT);
    assign empty    = (count == '0);
    assign do_push  = push && !full;
    assign do_pop   = pop && !empty;
    assign push_rej = push && full;
    assign pop_data = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) begin
                wptr <= (wptr == LAST_IDX) ? '0 : wptr + 1'b1;
            end
            if (do_pop) begin
                rptr <= (rptr == LAST_IDX) ? '0 : rptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/sync_tx_clkgen.sv
module sync_tx_clkgen
    import sync_tx_pkg::*;
#(
    parameter int unsigned DIV_HALF = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     run,
    input  logic     ext_sel,
    input  logic     ext_sclk,
    output sclk_ev_t ev,
    output logic     sclk_int
);
    localparam int unsigned DW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

    logic half_tick;
    logic int_fall, int_rise, ext_fall, ext_rise;
    logic ext_s1, ext_s2, ext_s3;

    generate
        if (DIV_HALF == 1) begin : g_nodiv
            assign half_tick = run && !ext_sel;
        end else begin : g_div
            localparam logic [DW-1:0] LAST = DW'(DIV_HALF - 1);
            logic [DW-1:0] cnt;
            always_ff @(posedge clk) begin
                if (rst || !run || ext_sel) begin
                    cnt <= '0;
                end else if (cnt == LAST) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
            assign half_tick = run && !ext_sel && (cnt == LAST);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || !run || ext_sel) begin
            sclk_int <= 1'b1;
        end else if (half_tick) begin
            sclk_int <= !sclk_int;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_s1 <= 1'b1;
            ext_s2 <= 1'b1;
            ext_s3 <= 1'b1;
        end else begin
            ext_s1 <= ext_sclk;
            ext_s2 <= ext_s1;
            ext_s3 <= ext_s2;
        end
    end

    assign int_fall = half_tick && sclk_int;
    assign int_rise = half_tick && !sclk_int;
    assign ext_fall = run && ext_sel && ext_s3 && !ext_s2;
    assign ext_rise = run && ext_sel && !ext_s3 && ext_s2;

    assign ev.fall = int_fall || ext_fall;
    assign ev.rise = int_rise || ext_rise;

endmodule

// File: rtl/sync_tx_shifter.sv
module sync_tx_shifter
    import sync_tx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     enable,
    input  logic     fifo_empty,
    input  tx_byte_t fifo_data,
    input  sclk_ev_t ev,
    output logic     pop,
    output logic     busy,
    output logic     txd,
    output logic     done_dry
);
    localparam logic [2:0] LAST_BIT = 3'(BITS_PER_FRAME - 1);

    shift_state_e state;
    tx_byte_t     sreg;
    logic [2:0]   idx;
    logic         armed;
    logic         frame_last, can_load;

    assign can_load   = enable && !fifo_empty;
    assign frame_last = (state == SH_SHIFT) && ev.rise && armed && (idx == LAST_BIT);
    assign pop        = ((state == SH_IDLE) && can_load) || (frame_last && can_load);
    assign done_dry   = frame_last && !can_load;
    assign busy       = (state == SH_SHIFT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SH_IDLE;
            sreg  <= '0;
            idx   <= '0;
            armed <= 1'b0;
            txd   <= 1'b1;
        end else begin
            case (state)
                SH_IDLE: begin
                    if (pop) begin
                        sreg  <= fifo_data;
                        idx   <= '0;
                        armed <= 1'b0;
                        state <= SH_SHIFT;
                    end
                end
                SH_SHIFT: begin
                    if (ev.fall) begin
                        txd   <= wire_bit(sreg, idx);
                        armed <= 1'b1;
                    end else if (ev.rise && armed) begin
                        armed <= 1'b0;
                        if (idx == LAST_BIT) begin
                            idx <= '0;
                            if (pop) begin
                                sreg <= fifo_data;
                            end else begin
                                state <= SH_IDLE;
                            end
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                default: state <= SH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sync_ser_tx.sv
module sync_ser_tx
    import sync_tx_pkg::*;
#(
    parameter int unsigned DEPTH    = 64,
    parameter int unsigned DIV_HALF = 4,
    localparam int unsigned CW      = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enable,
    input  logic          irq_en,
    input  logic          ext_clk_sel,
    input  logic [CW-1:0] trig_level,
    input  logic          flag_clr,
    input  logic          wr_valid,
    input  logic [7:0]    wr_data,
    input  logic          ext_sclk_in,
    output logic          sclk_out,
    output logic          txd,
    output logic          empty_flag,
    output logic          irq,
    output logic          tx_end,
    output logic          overflow,
    output logic [CW-1:0] fifo_count
);
    tx_byte_t fifo_rd;
    logic     fifo_full, fifo_empty, push_rej, pop, busy, done_dry;
    sclk_ev_t ev;
    logic     sclk_int;
    logic     wr_ok;

    sync_tx_fifo #(.DEPTH(DEPTH), .DW(8)) fifo_i (
        .clk       (clk),
        .rst       (rst),
        .push      (wr_valid),
        .push_data (wr_data),
        .pop       (pop),
        .pop_data  (fifo_rd),
        .count     (fifo_count),
        .full      (fifo_full),
        .empty     (fifo_empty),
        .push_rej  (push_rej)
    );

    sync_tx_clkgen #(.DIV_HALF(DIV_HALF)) clkgen_i (
        .clk      (clk),
        .rst      (rst),
        .run      (busy),
        .ext_sel  (ext_clk_sel),
        .ext_sclk (ext_sclk_in),
        .ev       (ev),
        .sclk_int (sclk_int)
    );

    sync_tx_shifter shifter_i (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .fifo_empty (fifo_empty),
        .fifo_data  (fifo_rd),
        .ev         (ev),
        .pop        (pop),
        .busy       (busy),
        .txd        (txd),
        .done_dry   (done_dry)
    );

    assign wr_ok    = wr_valid && !fifo_full;
    assign sclk_out = sclk_int;
    assign irq      = empty_flag && irq_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            empty_flag <= 1'b1;
            tx_end     <= 1'b1;
            overflow   <= 1'b0;
        end else begin
            if (fifo_count <= trig_level) begin
                empty_flag <= 1'b1;
            end else if (flag_clr) begin
                empty_flag <= 1'b0;
            end
            if (wr_ok) begin
                tx_end <= 1'b0;
            end else if (done_dry) begin
                tx_end <= 1'b1;
            end
            if (push_rej) begin
                overflow <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/sync_ser_tx_chk.sv
module sync_ser_tx_chk #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned CW    = 7
) (
    input logic          clk,
    input logic          rst,
    input logic          irq_en,
    input logic          ext_clk_sel,
    input logic [CW-1:0] trig_level,
    input logic          flag_clr,
    input logic          wr_valid,
    input logic          sclk_out,
    input logic          txd,
    input logic          empty_flag,
    input logic          irq,
    input logic          tx_end,
    input logic          overflow,
    input logic [CW-1:0] fifo_count
);
    assert_fifo_bound_R1: assert property (@(posedge clk) disable iff (rst)
        fifo_count <= CW'(DEPTH));

    assert_overflow_set_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && fifo_count == CW'(DEPTH)) |=> overflow);

    assert_overflow_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    assert_flag_set_R3: assert property (@(posedge clk) disable iff (rst)
        (fifo_count <= trig_level) |=> empty_flag);

    assert_flag_clear_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(empty_flag) |-> ($past(flag_clr) && ($past(fifo_count) > $past(trig_level))));

    assert_irq_source_R5: assert property (@(posedge clk) disable iff (rst)
        irq |-> (empty_flag && irq_en));

    assert_txd_on_fall_R7: assert property (@(posedge clk) disable iff (rst)
        (!ext_clk_sel && !$stable(txd)) |-> $fell(sclk_out));

    assert_hold_last_R9: assert property (@(posedge clk) disable iff (rst)
        (tx_end && $past(tx_end)) |-> $stable(txd));

    assert_tend_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && fifo_count < CW'(DEPTH)) |=> !tx_end);

    assert_idle_park_R11: assert property (@(posedge clk) disable iff (rst)
        tx_end |-> sclk_out);

    assert_ext_park_R11: assert property (@(posedge clk) disable iff (rst)
        ext_clk_sel |-> sclk_out);

endmodule

bind sync_ser_tx sync_ser_tx_chk #(.DEPTH(DEPTH), .CW(CW)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .irq_en      (irq_en),
    .ext_clk_sel (ext_clk_sel),
    .trig_level  (trig_level),
    .flag_clr    (flag_clr),
    .wr_valid    (wr_valid),
    .sclk_out    (sclk_out),
    .txd         (txd),
    .empty_flag  (empty_flag),
    .irq         (irq),
    .tx_end      (tx_end),
    .overflow    (overflow),
    .fifo_count  (fifo_count)
);

// File: tb/sync_ser_tx_tb_top.sv
module sync_ser_tx_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 64;
    localparam int DIV_HALF   = 4;
    localparam int CW         = $clog2(DEPTH + 1);
    localparam int NVEC       = 10;

    typedef struct packed {
        logic [7:0] stim;
        logic [7:0] exp;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{8'h01, 8'h01}, '{8'h80, 8'h80}, '{8'hA5, 8'hA5}, '{8'h5A, 8'h5A},
        '{8'hFF, 8'hFF}, '{8'h00, 8'h00}, '{8'h3C, 8'h3C}, '{8'hC3, 8'hC3},
        '{8'h12, 8'h12}, '{8'hE7, 8'hE7}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          enable = 1'b0, irq_en = 1'b0, ext_clk_sel = 1'b0;
    logic [CW-1:0] trig_level = '0;
    logic          flag_clr = 1'b0, wr_valid = 1'b0;
    logic [7:0]    wr_data = '0;
    logic          ext_sclk_in = 1'b1;
    logic          sclk_out, txd, empty_flag, irq, tx_end, overflow;
    logic [CW-1:0] fifo_count;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = !clk;

    sync_ser_tx #(.DEPTH(DEPTH), .DIV_HALF(DIV_HALF)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .enable      (enable),
        .irq_en      (irq_en),
        .ext_clk_sel (ext_clk_sel),
        .trig_level  (trig_level),
        .flag_clr    (flag_clr),
        .wr_valid    (wr_valid),
        .wr_data     (wr_data),
        .ext_sclk_in (ext_sclk_in),
        .sclk_out    (sclk_out),
        .txd         (txd),
        .empty_flag  (empty_flag),
        .irq         (irq),
        .tx_end      (tx_end),
        .overflow    (overflow),
        .fifo_count  (fifo_count)
    );

    // Receiver model: samples txd on each rising edge of sclk_out.
    logic [7:0] rx_buf [256];
    int         rx_n = 0, rises = 0, gap_bad = 0, bitc = 0, cyc = 0, last_rise = 0;
    bit         have_last = 1'b0;
    logic [7:0] sh = '0;
    logic       prev_s = 1'b1;

    always @(negedge clk) begin
        cyc++;
        if (!rst && !prev_s && sclk_out) begin
            sh = {txd, sh[7:1]};
            bitc++;
            rises++;
            if (have_last && (cyc - last_rise) != 2 * DIV_HALF) gap_bad++;
            have_last = 1'b1;
            last_rise = cyc;
            if (bitc == 8) begin
                rx_buf[rx_n[7:0]] = sh;
                rx_n++;
                bitc = 0;
            end
        end
        if (tx_end) have_last = 1'b0;
        prev_s = sclk_out;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic wait_tend();
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (tx_end) break;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int base;
        int r0;
        logic [7:0] ebyte;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // Reset state
        check("R1 count after reset", 32'(fifo_count), 0);
        check("R9 tx_end after reset", 32'(tx_end), 1);
        check("R11 sclk idle high", 32'(sclk_out), 1);
        check("R2 overflow after reset", 32'(overflow), 0);
        check("R3 flag after reset", 32'(empty_flag), 1);
        check("R5 irq masked", 32'(irq), 0);

        // Vector table: back-to-back burst in internal clock mode
        enable = 1'b1;
        base = rx_n;
        r0 = rises;
        for (int v = 0; v < NVEC; v++) wr(VECS[v].stim);
        wait_tend();
        repeat (4) @(negedge clk);
        for (int v = 0; v < NVEC; v++)
            check("R6 LSB-first byte", 32'(rx_buf[(base + v) % 256]), 32'(VECS[v].exp));
        check("R7 eight pulses per byte", 32'(rises - r0), 32'(8 * NVEC));
        check("R8 constant clock period, no gap", 32'(gap_bad), 0);
        check("R9 txd holds last bit", 32'(txd), 32'(VECS[NVEC-1].exp[7]));
        check("R11 clock parked high", 32'(sclk_out), 1);
        check("R1 FIFO drained", 32'(fifo_count), 0);

        // Trigger / flag / interrupt
        enable = 1'b0;
        trig_level = CW'(2);
        irq_en = 1'b1;
        @(negedge clk);
        check("R5 irq raised", 32'(irq), 1);
        wr(8'h11); wr(8'h22); wr(8'h33);
        @(negedge clk);
        check("R1 count after three writes", 32'(fifo_count), 3);
        check("R4 flag not self-clearing", 32'(empty_flag), 1);
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
        check("R4 flag cleared by strobe", 32'(empty_flag), 0);
        check("R5 irq follows flag", 32'(irq), 0);
        base = rx_n;
        enable = 1'b1;
        repeat (3) @(negedge clk);
        check("R3 flag set at trigger count", 32'(empty_flag), 1);
        check("R5 irq on flag", 32'(irq), 1);
        wait_tend();
        repeat (4) @(negedge clk);
        check("R6 byte 0x11", 32'(rx_buf[base % 256]), 32'h11);
        check("R6 byte 0x33", 32'(rx_buf[(base + 2) % 256]), 32'h33);
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
        @(negedge clk);
        check("R4 strobe ignored at or below trigger", 32'(empty_flag), 1);
        irq_en = 1'b0;
        @(negedge clk);
        check("R5 irq disabled", 32'(irq), 0);

        // Enable gating
        enable = 1'b0;
        trig_level = '0;
        r0 = rises;
        base = rx_n;
        wr(8'h5A);
        check("R10 tx_end cleared by write", 32'(tx_end), 0);
        repeat (40) @(negedge clk);
        check("R12 byte held while disabled", 32'(fifo_count), 1);
        check("R12 no clock while disabled", 32'(rises - r0), 0);
        enable = 1'b1;
        wait_tend();
        repeat (4) @(negedge clk);
        check("R12 byte sent after enable", 32'(rx_buf[base % 256]), 32'h5A);

        // Overflow with a full FIFO, then a long drain
        enable = 1'b0;
        base = rx_n;
        for (int i = 0; i < DEPTH + 1; i++) wr(8'((i * 7 + 3) & 8'hFF));
        @(negedge clk);
        check("R1 FIFO holds 64", 32'(fifo_count), 32'(DEPTH));
        check("R2 overflow set", 32'(overflow), 1);
        enable = 1'b1;
        wait_tend();
        repeat (4) @(negedge clk);
        check("R2 only 64 bytes sent", 32'(rx_n - base), 32'(DEPTH));
        for (int i = 0; i < DEPTH; i++)
            check("R2 drained byte order", 32'(rx_buf[(base + i) % 256]), 32'((i * 7 + 3) & 8'hFF));
        check("R8 no gap over full drain", 32'(gap_bad), 0);
        check("R2 overflow sticky", 32'(overflow), 1);

        // External clock mode
        ext_clk_sel = 1'b1;
        ext_sclk_in = 1'b1;
        wr(8'hA5);
        wr(8'h3C);
        repeat (4) @(negedge clk);
        for (int b = 0; b < 2; b++) begin
            ebyte = '0;
            for (int k = 0; k < 8; k++) begin
                ext_sclk_in = 1'b0;
                repeat (6) @(negedge clk);
                ebyte[k] = txd;
                check("R11 clock pin high in external mode", 32'(sclk_out), 1);
                ext_sclk_in = 1'b1;
                repeat (6) @(negedge clk);
            end
            check("R13 external-clock byte", 32'(ebyte), (b == 0) ? 32'hA5 : 32'h3C);
        end
        repeat (4) @(negedge clk);
        check("R9 tx_end after external frames", 32'(tx_end), 1);
        check("R9 txd holds last external bit", 32'(txd), 0);

        summary();
    end

endmodule